// File: doc/BRIEF.md
# Token-Passing Parallel Host Bus Master

This controller sits on the host side of an 8-bit parallel link to a network transceiver. It runs every bus access itself: it sets the address-select and read/write lines, holds an active-low chip select for a programmed number of cycles, and drives the data lines only while it writes. The data bus is split into an output value, an output enable and an input value, so the pad ring can build the three-state buffer. Address select high picks the peer's status byte, and bit 0 of that byte is the handshake flag. Address select low picks a data byte.

Ownership of the link moves with a write token. The controller comes out of reset holding the token. While it holds the token, it writes downlink bytes taken from a valid/ready stream. The byte flagged last hands the token to the peer. If no message is in progress and the peer raises its interrupt, the controller writes one 0x00 byte as a null token, so that the peer can send. While the peer holds the token and its interrupt is high, the controller reads uplink bytes and passes them out on a valid/ready stream. It gets the token back when the interrupt is low after a byte has been delivered.

Before every data byte, the controller polls the handshake flag. If the peer stays busy for too many polls, it raises an error flag and stops.

Top module: `tok_host_if`

## Requirements
- R1: While reset is asserted and right after it, chip select is high, the data drive enable is low, the token flag is 1 (host holds the token), and the uplink valid and timeout flags are 0.
- R2: In every access, address select and read/write are set at least one cycle before chip select falls and stay stable while it is low. Chip select stays low for exactly the programmed hold count, and a count of 0 acts as 1.
- R3: Read/write is 1 for a read and 0 for a write. Address select 1 reads the status byte, which is always a read. Address select 0 accesses a data byte.
- R4: The data drive enable is high only while chip select is low and read/write is 0.
- R5: Every data access follows a status read whose bit 0 was 0 (0 = ready, 1 = busy). Busy reads are repeated.
- R6: When the number of busy status reads for one byte reaches the poll limit, the timeout flag rises and no data access is made. The flag stays set, and no further bus access occurs until reset.
- R7: While the host holds the token, downlink bytes are written in stream order, one per dn_ready pulse. Writing the byte marked last clears the token flag.
- R8: While the host holds the token, with no message in progress and no downlink byte offered, an asserted interrupt causes exactly one write of 0x00, after which the token flag is 0.
- R9: Between bytes of a downlink message that is not yet finished, an asserted interrupt causes no null-token write.
- R10: While the peer holds the token and its interrupt is high, data bytes are read and delivered upstream in bus order. After each delivery, a low interrupt returns the token (flag 1) and a high one leads to another read.
- R11: An uplink byte stays valid, with unchanged data, until up_ready_i accepts it.
- R12: While the peer holds the token and the interrupt is low, no bus access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_cycles_i | input | 4 | Chip select low time in cycles (0 acts as 1) |
| poll_limit_i | input | 16 | Busy status reads allowed per byte |
| irq_i | input | 1 | Peer interrupt: uplink data waiting |
| bus_a0_o | output | 1 | Address select: 1 status, 0 data |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rw_o | output | 1 | 1 read, 0 write |
| bus_d_o | output | 8 | Data bus drive value |
| bus_d_oe_o | output | 1 | Data bus drive enable |
| bus_d_i | input | 8 | Data bus input value |
| dn_data_i | input | 8 | Downlink byte |
| dn_last_i | input | 1 | Downlink byte ends the message |
| dn_valid_i | input | 1 | Downlink byte offered |
| dn_ready_o | output | 1 | Downlink byte written |
| up_data_o | output | 8 | Uplink byte |
| up_valid_o | output | 1 | Uplink byte offered |
| up_ready_i | input | 1 | Uplink byte accepted |
| token_o | output | 1 | 1 while the host holds the write token |
| timeout_o | output | 1 | Handshake poll limit exceeded |

## Verification
The hardest case to reach is a downlink message that has started but is not yet finished while the interrupt is raised. The controller then holds the token with nothing offered, which would otherwise trigger a null token. The bench stops the downlink stream after a non-final byte, raises the interrupt with an uplink byte queued, and waits. It then sends the final byte and checks that the peer model saw only the two message bytes before the read. The timeout path is reached by keeping the peer model's busy flag set for far longer than a small poll limit. The bench then counts the status reads and confirms that the bus stays silent afterwards.

// File: rtl/tok_host_pkg.sv
package tok_host_pkg;
  localparam int unsigned STATUS_BIT = 0;

  typedef enum logic [1:0] {BC_IDLE, BC_SETUP, BC_STROBE} bc_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_POLL_GO, SQ_POLL_WAIT, SQ_DATA_GO, SQ_DATA_WAIT, SQ_DELIVER
  } sq_state_e;

  typedef enum logic [1:0] {XF_WRITE, XF_NULL, XF_READ} xfer_e;
endpackage

// File: rtl/tok_bus_cycle.sv
module tok_bus_cycle
  import tok_host_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              a0_i,
  input  logic              rw_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              bus_a0_o,
  output logic              bus_cs_no,
  output logic              bus_rw_o,
  output logic [DW-1:0]     bus_d_o,
  output logic              bus_d_oe_o,
  input  logic [DW-1:0]     bus_d_i
);
  bc_state_e         st_q;
  logic              a0_q, rw_q, done_q;
  logic [DW-1:0]     wd_q, rd_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BC_IDLE;
      a0_q   <= 1'b0;
      rw_q   <= 1'b1;
      wd_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        BC_IDLE: if (start_i) begin
          a0_q <= a0_i;
          rw_q <= rw_i;
          wd_q <= wdata_i;
          st_q <= BC_SETUP;
        end
        BC_SETUP: begin
          cnt_q <= (hold_i == '0) ? '0 : hold_i - 1'b1;
          st_q  <= BC_STROBE;
        end
        BC_STROBE: begin
          if (cnt_q == '0) begin
            rd_q   <= bus_d_i;
            done_q <= 1'b1;
            st_q   <= BC_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  assign bus_a0_o   = a0_q;
  assign bus_rw_o   = rw_q;
  assign bus_cs_no  = (st_q != BC_STROBE);
  assign bus_d_oe_o = (st_q == BC_STROBE) && !rw_q;
  assign bus_d_o    = bus_d_oe_o ? wd_q : '0;
  assign done_o     = done_q;
  assign rdata_o    = rd_q;

  assert_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_cs_no) |-> $stable(bus_a0_o) && $stable(bus_rw_o));

  assert_cs_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && $past(!bus_cs_no)) |-> $stable(bus_a0_o) && $stable(bus_rw_o));
endmodule

// File: rtl/tok_seq.sv
module tok_seq
  import tok_host_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POLL_W-1:0] poll_limit_i,
  input  logic              irq_i,
  input  logic [DW-1:0]     dn_data_i,
  input  logic              dn_last_i,
  input  logic              dn_valid_i,
  output logic              dn_ready_o,
  output logic [DW-1:0]     up_data_o,
  output logic              up_valid_o,
  input  logic              up_ready_i,
  output logic              token_o,
  output logic              timeout_o,
  output logic              start_o,
  output logic              a0_o,
  output logic              rw_o,
  output logic [DW-1:0]     wdata_o,
  input  logic              done_i,
  input  logic [DW-1:0]     rdata_i
);
  sq_state_e         st_q;
  xfer_e             mode_q;
  logic              token_q, in_msg_q, timeout_q, up_valid_q;
  logic [DW-1:0]     up_data_q;
  logic [POLL_W-1:0] poll_cnt_q;
  logic              limit_hit;

  assign limit_hit = ({1'b0, poll_cnt_q} + 1'b1) >= {1'b0, poll_limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      mode_q     <= XF_WRITE;
      token_q    <= 1'b1;
      in_msg_q   <= 1'b0;
      timeout_q  <= 1'b0;
      up_valid_q <= 1'b0;
      up_data_q  <= '0;
      poll_cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          poll_cnt_q <= '0;
          if (!timeout_q) begin
            if (token_q) begin
              if (dn_valid_i) begin
                mode_q <= XF_WRITE;
                st_q   <= SQ_POLL_GO;
              end else if (irq_i && !in_msg_q) begin
                mode_q <= XF_NULL;
                st_q   <= SQ_POLL_GO;
              end
            end else if (irq_i) begin
              mode_q <= XF_READ;
              st_q   <= SQ_POLL_GO;
            end
          end
        end
        SQ_POLL_GO: st_q <= SQ_POLL_WAIT;
        SQ_POLL_WAIT: if (done_i) begin
          if (!rdata_i[STATUS_BIT]) begin
            st_q <= SQ_DATA_GO;
          end else if (limit_hit) begin
            timeout_q <= 1'b1;
            st_q      <= SQ_IDLE;
          end else begin
            poll_cnt_q <= poll_cnt_q + 1'b1;
            st_q       <= SQ_POLL_GO;
          end
        end
        SQ_DATA_GO: st_q <= SQ_DATA_WAIT;
        SQ_DATA_WAIT: if (done_i) begin
          unique case (mode_q)
            XF_WRITE: begin
              in_msg_q <= !dn_last_i;
              if (dn_last_i) token_q <= 1'b0;
              st_q <= SQ_IDLE;
            end
            XF_NULL: begin
              token_q <= 1'b0;
              st_q    <= SQ_IDLE;
            end
            default: begin
              up_data_q  <= rdata_i;
              up_valid_q <= 1'b1;
              st_q       <= SQ_DELIVER;
            end
          endcase
        end
        SQ_DELIVER: if (up_ready_i) begin
          up_valid_q <= 1'b0;
          if (!irq_i) token_q <= 1'b1;
          st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign start_o    = (st_q == SQ_POLL_GO) || (st_q == SQ_DATA_GO);
  assign a0_o       = (st_q == SQ_POLL_GO);
  assign rw_o       = (st_q == SQ_POLL_GO) || (mode_q == XF_READ);
  assign wdata_o    = (mode_q == XF_NULL) ? '0 : dn_data_i;
  assign dn_ready_o = (st_q == SQ_DATA_WAIT) && done_i && (mode_q == XF_WRITE);
  assign up_data_o  = up_data_q;
  assign up_valid_o = up_valid_q;
  assign token_o    = token_q;
  assign timeout_o  = timeout_q;

  assert_data_after_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !a0_o) |-> ($past(done_i) && !rdata_i[STATUS_BIT]));

  assert_up_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_o && !up_ready_i) |=> (up_valid_o && $stable(up_data_o)));

  assert_timeout_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> (timeout_o && !start_o));
endmodule

// File: rtl/tok_host_if.sv
module tok_host_if
  import tok_host_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned HOLD_W = 4,
  parameter int unsigned POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  input  logic              irq_i,
  output logic              bus_a0_o,
  output logic              bus_cs_no,
  output logic              bus_rw_o,
  output logic [DW-1:0]     bus_d_o,
  output logic              bus_d_oe_o,
  input  logic [DW-1:0]     bus_d_i,
  input  logic [DW-1:0]     dn_data_i,
  input  logic              dn_last_i,
  input  logic              dn_valid_i,
  output logic              dn_ready_o,
  output logic [DW-1:0]     up_data_o,
  output logic              up_valid_o,
  input  logic              up_ready_i,
  output logic              token_o,
  output logic              timeout_o
);
  logic          start, a0, rw, done;
  logic [DW-1:0] wdata, rdata;

  tok_seq #(.DW(DW), .POLL_W(POLL_W)) u_seq (
    .clk_i, .rst_ni, .poll_limit_i, .irq_i,
    .dn_data_i, .dn_last_i, .dn_valid_i, .dn_ready_o,
    .up_data_o, .up_valid_o, .up_ready_i, .token_o, .timeout_o,
    .start_o(start), .a0_o(a0), .rw_o(rw), .wdata_o(wdata),
    .done_i(done), .rdata_i(rdata)
  );

  tok_bus_cycle #(.DW(DW), .HOLD_W(HOLD_W)) u_bus (
    .clk_i, .rst_ni, .start_i(start), .a0_i(a0), .rw_i(rw), .wdata_i(wdata),
    .hold_i(hold_cycles_i), .done_o(done), .rdata_o(rdata),
    .bus_a0_o, .bus_cs_no, .bus_rw_o, .bus_d_o, .bus_d_oe_o, .bus_d_i
  );
endmodule

// File: tb/tok_host_if_test.sv
module tok_host_if_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] hold_cycles = 4'd2;
  logic [15:0] poll_limit = 16'd10;
  logic       irq = 1'b0;
  logic       bus_a0, bus_cs_n, bus_rw, bus_d_oe;
  logic [7:0] bus_d_o, bus_d_i;
  logic [7:0] dn_data = '0;
  logic       dn_last = 1'b0, dn_valid = 1'b0, dn_ready;
  logic [7:0] up_data;
  logic       up_valid, up_ready = 1'b1, token, timeout;

  always #4 clk = ~clk;

  tok_host_if uut (
    .clk_i(clk), .rst_ni, .hold_cycles_i(hold_cycles), .poll_limit_i(poll_limit),
    .irq_i(irq), .bus_a0_o(bus_a0), .bus_cs_no(bus_cs_n), .bus_rw_o(bus_rw),
    .bus_d_o, .bus_d_oe_o(bus_d_oe), .bus_d_i,
    .dn_data_i(dn_data), .dn_last_i(dn_last), .dn_valid_i(dn_valid), .dn_ready_o(dn_ready),
    .up_data_o(up_data), .up_valid_o(up_valid), .up_ready_i(up_ready),
    .token_o(token), .timeout_o(timeout)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // peer model
  logic [7:0] up_q[$], exp_wr[$], exp_up[$];
  int busy_cfg = 2, busy_left = 2, exp_hold = 2, low_w = 0;
  int n_stat = 0, n_wr = 0, n_rd = 0, oe_bad = 0, dn_acc = 0;
  bit prev_cs = 1'b1, last_ready = 1'b0, busy_bit = 1'b1;
  logic [7:0] peer_byte = '0, wr_lat = '0;
  assign bus_d_i = bus_a0 ? {7'b0, busy_bit} : peer_byte;

  always @(negedge clk) begin
    if (bus_d_oe && (bus_cs_n || bus_rw)) oe_bad++;
    if (!bus_cs_n) begin
      low_w++;
      if (bus_d_oe) wr_lat = bus_d_o;
    end else if (!prev_cs) begin
      chk(low_w == exp_hold, "R2 cs low width", low_w, exp_hold);
      if (bus_a0) begin
        chk(bus_rw, "R3 status read has rw=1", bus_rw, 1);
        n_stat++;
        last_ready = !busy_bit;
        if (busy_left > 0) busy_left--;
      end else begin
        chk(last_ready, "R5 data access after ready status", last_ready, 1);
        last_ready = 1'b0;
        busy_left = busy_cfg;
        if (!bus_rw) begin
          n_wr++;
          if (exp_wr.size() == 0) chk(0, "R7/R8 unexpected write", wr_lat, 0);
          else begin
            logic [7:0] e;
            e = exp_wr.pop_front();
            chk(wr_lat == e, "R7/R8 written byte", wr_lat, e);
          end
        end else begin
          n_rd++;
          if (up_q.size() > 0) void'(up_q.pop_front());
          if (up_q.size() == 0) irq = 1'b0;
        end
      end
      low_w = 0;
    end
    prev_cs = bus_cs_n;
    busy_bit = (busy_left != 0);
    peer_byte = (up_q.size() > 0) ? up_q[0] : 8'hEE;
  end

  // uplink monitor
  bit held = 1'b0;
  logic [7:0] held_d = '0;
  always begin
    @(negedge clk); #1;
    if (rst_ni) begin
      if (held) begin
        chk(up_valid && up_data == held_d, "R11 uplink byte held", up_data, held_d);
      end
      if (dn_ready && dn_valid) dn_acc++;
      if (up_valid && up_ready) begin
        if (exp_up.size() == 0) chk(0, "R10 unexpected uplink byte", up_data, 0);
        else begin
          logic [7:0] e;
          e = exp_up.pop_front();
          chk(up_data == e, "R10 uplink byte order", up_data, e);
        end
      end
      held = up_valid && !up_ready;
      held_d = up_data;
    end
  end

  task automatic send_msg(input logic [7:0] b[], input bit end_msg);
    foreach (b[i]) begin
      exp_wr.push_back(b[i]);
      dn_valid = 1'b1;
      dn_data = b[i];
      dn_last = end_msg && (i == b.size() - 1);
      do @(negedge clk); while (!dn_ready);
      @(posedge clk);
      @(negedge clk);
    end
    dn_valid = 1'b0;
    dn_last = 1'b0;
  endtask

  task automatic wait_token(input bit v);
    for (int i = 0; i < 3000 && token !== v; i++) @(negedge clk);
  endtask

  task automatic finish_test;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_test();
  end

  initial begin
    int s0, w0, r0;
    repeat (2) @(negedge clk);
    // R1 during and after reset
    chk(bus_cs_n && !bus_d_oe && token && !up_valid && !timeout, "R1 in reset",
        {bus_cs_n, bus_d_oe, token, up_valid, timeout}, 5'b10100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && !bus_d_oe && token && !up_valid && !timeout, "R1 after reset",
        {bus_cs_n, bus_d_oe, token, up_valid, timeout}, 5'b10100);

    // R7 R5 message write with busy polls, hold 2
    send_msg('{8'h11, 8'h22, 8'h33}, 1'b1);
    chk(token == 1'b0, "R7 token passed after last", token, 0);
    repeat (10) @(negedge clk);
    chk(n_wr == 3, "R7 write count", n_wr, 3);
    chk(n_stat == 9, "R5 status polls per byte", n_stat, 9);

    // R12 peer holds token, irq low
    s0 = n_stat; w0 = n_wr; r0 = n_rd;
    repeat (40) @(negedge clk);
    chk(n_stat + n_wr + n_rd == s0 + w0 + r0, "R12 bus idle", n_stat + n_wr + n_rd, s0 + w0 + r0);

    // R10 uplink read, hold 1
    hold_cycles = 4'd1; exp_hold = 1; busy_cfg = 0; busy_left = 0;
    up_q = '{8'hA1, 8'hA2, 8'hA3}; exp_up = '{8'hA1, 8'hA2, 8'hA3};
    irq = 1'b1;
    wait_token(1'b1);
    repeat (4) @(negedge clk);
    chk(token == 1'b1, "R10 token returned", token, 1);
    chk(n_rd == r0 + 3, "R10 read count", n_rd, r0 + 3);
    chk(exp_up.size() == 0, "R10 all bytes delivered", exp_up.size(), 0);

    // R8 null token, hold 5, with uplink backpressure (R11)
    hold_cycles = 4'd5; exp_hold = 5; busy_cfg = 1; busy_left = 1;
    up_ready = 1'b0;
    w0 = n_wr;
    exp_wr.push_back(8'h00);
    up_q = '{8'hB1}; exp_up = '{8'hB1};
    irq = 1'b1;
    for (int i = 0; i < 2000 && !up_valid; i++) @(negedge clk);
    chk(n_wr == w0 + 1, "R8 single null write", n_wr, w0 + 1);
    chk(token == 1'b0, "R8 token passed by null", token, 0);
    repeat (6) @(negedge clk);
    chk(up_valid && up_data == 8'hB1, "R11 byte held under backpressure", up_data, 8'hB1);
    up_ready = 1'b1;
    wait_token(1'b1);
    chk(token == 1'b1 && exp_up.size() == 0, "R10 token back after null round", token, 1);

    // R9 no null token mid message, hold 0 acts as 1
    hold_cycles = 4'd0; exp_hold = 1;
    send_msg('{8'hC1}, 1'b0);
    w0 = n_wr;
    up_q = '{8'hD1}; exp_up = '{8'hD1};
    irq = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_wr == w0, "R9 no write while message open", n_wr, w0);
    chk(token == 1'b1, "R9 token still held", token, 1);
    send_msg('{8'hC2}, 1'b1);
    wait_token(1'b0);
    wait_token(1'b1);
    chk(exp_wr.size() == 0 && exp_up.size() == 0, "R9 scoreboards drained",
        exp_wr.size() + exp_up.size(), 0);

    // R6 timeout
    hold_cycles = 4'd2; exp_hold = 2; poll_limit = 16'd4;
    busy_cfg = 1000; busy_left = 1000;
    s0 = n_stat; w0 = n_wr; r0 = dn_acc;
    dn_valid = 1'b1; dn_data = 8'h5A; dn_last = 1'b1;
    for (int i = 0; i < 500 && !timeout; i++) @(negedge clk);
    chk(timeout == 1'b1, "R6 timeout raised", timeout, 1);
    dn_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_stat == s0 + 4, "R6 busy polls equal limit", n_stat - s0, 4);
    chk(n_wr == w0 && dn_acc == r0, "R6 no data write", n_wr - w0, 0);
    chk(timeout == 1'b1, "R6 flag stays set", timeout, 1);
    chk(oe_bad == 0, "R4 drive only during write strobe", oe_bad, 0);

    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!timeout && token && bus_cs_n, "R1 reset clears timeout", {timeout, token, bus_cs_n}, 3'b011);
    finish_test();
  end
endmodule